// File: doc/BRIEF.md
# Refresh Request Tracker with Backlog

This block turns a slow, free-running refresh clock into a steady stream of DRAM refresh requests. It also remembers the requests that a busy memory sequencer could not serve at once. Every 64 rising edges of the refresh clock produce one request. That request crosses into the main controller clock domain and is added to a backlog counter. The backlog saturates at 128 outstanding requests.

The memory sequencer watches `refresh_pending`. Whenever the current access finishes, the sequencer runs row-only refresh cycles back to back and pulses `refresh_done` once for each one, until the backlog drains to zero. The block also keeps the 10-bit refresh row address that the sequencer drives onto the DRAM address lines. That address starts at all ones and moves up by one with every refresh served.

Top module: `refresh_tracker`

## Requirements
- R1: After reset, one refresh request is raised for every 64 rising edges of `rcp_clk`. The first request follows the 64th edge, and 63 edges alone raise none.
- R2: The request crosses into the `clk` domain through a two-flop synchronizer and an edge detector. The backlog grows within six `clk` cycles of the 64th `rcp_clk` edge.
- R3: Reset clears the backlog, so `refresh_pending` is 0, and sets `refresh_addr` to 10'h3FF.
- R4: The backlog holds at most 128 requests. A request that arrives while the backlog is 128 is dropped.
- R5: `refresh_pending` is 1 exactly while the backlog is nonzero. With `refresh_done` high every cycle, it stays high for exactly as many cycles as there are outstanding requests.
- R6: A `refresh_done` taken while `refresh_pending` is 1 lowers the backlog by one.
- R7: Each accepted `refresh_done` raises `refresh_addr` by one, and the address wraps from 10'h3FF to 10'h000.
- R8: A `refresh_done` while `refresh_pending` is 0 is ignored. Neither the backlog nor `refresh_addr` changes.
- R9: When a new request and an accepted `refresh_done` fall in the same `clk` cycle, the backlog stays unchanged, and the address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| rcp_clk | input | 1 | Slow refresh time-base clock |
| refresh_done | input | 1 | One pulse per refresh cycle completed by the sequencer |
| refresh_pending | output | 1 | High while refresh requests are outstanding |
| refresh_addr | output | 10 | Row address for the next refresh cycle |

## Verification
The bench targets the divide boundary first: 63 edges must leave `refresh_pending` low and the 64th must raise it. An off-by-one divider fails one of these two checks. It then overfills the backlog with 130 requests and counts the drain cycles. A counter that wraps past 128 would drain in 1 or 2 cycles, and one that never stops would drain in 130. A sequencer strobe sent while the backlog is empty must leave the address alone, so a design that steps the address anyway shows a shifted row address. A request landing in the middle of a burst of done pulses must survive, so a design that lets the done pulse win leaves the backlog one short.

// File: rtl/rtrk_pkg.sv
package rtrk_pkg;

  function automatic int unsigned backlog_step(input int unsigned cur,
                                               input logic add,
                                               input logic sub,
                                               input int unsigned cap);
    int unsigned nxt;
    nxt = cur;
    if (add && !sub && cur < cap) nxt = cur + 1;
    else if (sub && !add && cur > 0) nxt = cur - 1;
    return nxt;
  endfunction

  function automatic logic [9:0] row_step(input logic [9:0] cur);
    return cur + 10'd1;
  endfunction

endpackage

// File: rtl/rtrk_rcp_divider.sv
module rtrk_rcp_divider #(
  parameter int DIV = 64
) (
  input  logic rcp_clk,
  input  logic rst_n,
  output logic tick_toggle
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] phase;
  logic          wrap;

  assign wrap = (phase == CW'(DIV - 1));

  always_ff @(posedge rcp_clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= '0;
      tick_toggle <= 1'b0;
    end else begin
      phase <= wrap ? '0 : phase + 1'b1;
      if (wrap) tick_toggle <= ~tick_toggle;
    end
  end

  p_toggle_on_wrap_r1: assert property (@(posedge rcp_clk) disable iff (!rst_n)
    !wrap |=> $stable(tick_toggle));
endmodule

// File: rtl/rtrk_event_sync.sv
module rtrk_event_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_toggle,
  output logic event_pulse
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_toggle;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign event_pulse = sync_q ^ last_q;

  // R2: one toggle yields a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |=> !event_pulse);
endmodule

// File: rtl/rtrk_backlog.sv
module rtrk_backlog
  import rtrk_pkg::*;
#(
  parameter int MAX_PEND = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic new_req,
  input  logic done_in,
  output logic done_acc,
  output logic pending
);
  localparam int BW = $clog2(MAX_PEND + 1);

  logic [BW-1:0] count;
  logic [BW-1:0] count_nxt;

  assign pending  = (count != '0);
  assign done_acc = done_in && pending;
  assign count_nxt = BW'(backlog_step(int'(count), new_req, done_acc, MAX_PEND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= BW'(MAX_PEND));

  p_drop_at_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == BW'(MAX_PEND) && new_req && !done_acc) |=> count == BW'(MAX_PEND));

  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && !new_req) |=> count == $past(count) - 1'b1);

  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && new_req) |=> $stable(count));

  p_ignore_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !new_req) |=> !pending);
endmodule

// File: rtl/rtrk_row_counter.sv
module rtrk_row_counter
  import rtrk_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [AW-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row <= '1;
    else if (advance) row <= AW'(row_step(10'(row)));
  end

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> row == AW'($past(row) + 1'b1));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row));
endmodule

// File: rtl/refresh_tracker.sv
module refresh_tracker #(
  parameter int DIV      = 64,
  parameter int MAX_PEND = 128,
  parameter int AW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rcp_clk,
  input  logic          refresh_done,
  output logic          refresh_pending,
  output logic [AW-1:0] refresh_addr
);
  logic tick_toggle;
  logic req_pulse;
  logic done_taken;

  rtrk_rcp_divider #(.DIV(DIV)) u_div (
    .rcp_clk     (rcp_clk),
    .rst_n       (rst_n),
    .tick_toggle (tick_toggle)
  );

  rtrk_event_sync u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .async_toggle (tick_toggle),
    .event_pulse  (req_pulse)
  );

  rtrk_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_req  (req_pulse),
    .done_in  (refresh_done),
    .done_acc (done_taken),
    .pending  (refresh_pending)
  );

  rtrk_row_counter #(.AW(AW)) u_row (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (done_taken),
    .row     (refresh_addr)
  );

  // R5: the address never moves unless a refresh was outstanding
  p_addr_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_addr != $past(refresh_addr)) |-> $past(refresh_pending));
endmodule

// File: tb/sim_refresh_tracker.sv
module sim_refresh_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rcp_clk = 1'b0;
  logic       refresh_done = 1'b0;
  logic       refresh_pending;
  logic [9:0] refresh_addr;

  int checks = 0;
  int errors = 0;
  int served = 0;
  bit finished = 1'b0;

  refresh_tracker u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .rcp_clk         (rcp_clk),
    .refresh_done    (refresh_done),
    .refresh_pending (refresh_pending),
    .refresh_addr    (refresh_addr)
  );

  always #4 clk = ~clk;

  function automatic logic [9:0] exp_addr(input int n);
    return 10'((1023 + n) % 1024);
  endfunction

  function automatic int exp_backlog(input int reqs);
    return (reqs > 128) ? 128 : reqs;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic rcp_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      rcp_clk = 1'b1; #5;
      rcp_clk = 1'b0; #5;
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic drain(output int cycles);
    cycles = 0;
    @(negedge clk);
    while (refresh_pending && cycles < 300) begin
      refresh_done = 1'b1;
      cycles++;
      @(negedge clk);
    end
    refresh_done = 1'b0;
    served += cycles;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    if (refresh_pending) served++;
    refresh_done = 1'b1;
    @(negedge clk);
    refresh_done = 1'b0;
  endtask

  initial begin
    int got;
    int n;
    int k;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 pending", refresh_pending, 0);
    check("R3 addr", refresh_addr, exp_addr(0));

    rcp_ticks(63); settle();
    check("R1 63 edges", refresh_pending, 0);
    rcp_ticks(1); settle();
    check("R1 R2 64th edge", refresh_pending, 1);
    drain(got);
    check("R5 drain one", got, 1);
    check("R7 wrap to zero", refresh_addr, exp_addr(served));

    for (int i = 0; i < 5; i++) pulse_done();
    check("R8 idle done pending", refresh_pending, 0);
    check("R8 idle done addr", refresh_addr, exp_addr(served));

    for (int it = 0; it < 6; it++) begin
      n = $urandom_range(1, 6);
      k = $urandom_range(0, n);
      rcp_ticks(64 * n); settle();
      for (int j = 0; j < k; j++) pulse_done();
      check("R7 partial addr", refresh_addr, exp_addr(served));
      check("R6 pending after partial", refresh_pending, (n - k) > 0 ? 1 : 0);
      drain(got);
      check("R6 remaining backlog", got, n - k);
    end

    rcp_ticks(64 * 130); settle();
    check("R4 saturated pending", refresh_pending, 1);
    drain(got);
    check("R4 R5 drain at cap", got, exp_backlog(130));
    check("R7 addr after cap", refresh_addr, exp_addr(served));

    rcp_ticks(64 * 8); settle();
    rcp_ticks(64);
    @(negedge clk);
    refresh_done = 1'b1;
    repeat (6) @(negedge clk);
    refresh_done = 1'b0;
    served += 6;
    check("R9 addr during overlap", refresh_addr, exp_addr(served));
    settle();
    drain(got);
    check("R9 backlog after overlap", got, 3);
    check("R7 final addr", refresh_addr, exp_addr(served));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule